// File: doc/BRIEF.md
# Sequenced Audio Clock-Enable Divider Tree

This block derives all converter timing from one codec input clock. It does not make new clocks. Each divider emits a one-cycle clock-enable pulse in the input clock domain. The playback side cascades three dividers: a pre-divider, a modulator divider and an oversampling divider. The first two set the playback modulator rate. The third sets the playback sample rate. The record side has the same three stages.

Each pre-divider and modulator divider has two inputs from software: a divide value and an enable request. Raising a request starts the divider at the next clock edge. Dropping a request does not stop the divider at once. A sequencer keeps the divider running until three things are true: the channel's power-status inputs report that the channel is powered down, every divider fed by this one has already stopped, and no borrowing channel still needs it.

When both record-side pre and modulator dividers are stopped, the record oversampling divider is fed from the playback modulator enables. In that state the playback dividers also serve the record side. A set of status outputs shows which dividers are actually running, as opposed to merely requested.

Top module: `audio_ce_tree`

## Requirements
- R1: With both playback dividers running at values N and M (1..127), `pb_mod_ce` pulses once every N·M cycles, and `pb_fs_ce` pulses once every N·M·O cycles, where O is the playback oversampling value.
- R2: With both record dividers running at values N and M, `rec_mod_ce` pulses every N·M cycles and `rec_fs_ce` every N·M·O cycles, where O is the record oversampling value.
- R3: A divide value of 0 selects the largest count of its field: 128 for the 7-bit pre and modulator dividers, 1024 for the 10-bit playback oversampling divider, and 256 for the 8-bit record oversampling divider.
- R4: A divide value is captured only while its divider is stopped. Changing it while the divider runs has no effect until the divider has been stopped and restarted.
- R5: A raised enable request sets the matching running flag at the next clock edge. With N=M=1 the playback modulator enable pulses in that first running cycle.
- R6: After the playback requests drop, both playback dividers keep running until both playback power-status inputs (`pb_pwr_dn_a`, `pb_pwr_dn_b`) are 1.
- R7: After the record requests drop, both record dividers keep running until `rec_pwr_dn` is 1.
- R8: Within a channel, once shutdown is allowed, the modulator divider stops first. The pre-divider stops one cycle later. A pre-divider never stops while its modulator divider runs.
- R9: While both record pre and modulator dividers are stopped, `rec_mod_ce` equals `pb_mod_ce`, and `rec_fs_ce` divides those pulses by the record oversampling value.
- R10: While the record side borrows the playback dividers and `rec_pwr_dn` is 0, the playback dividers keep running even when their requests are low and both playback status inputs are 1.
- R11: A channel whose modulator divider is not running emits no modulator or sample enable, even when its pre-divider runs. The running flags (`pb_pre_on`, `pb_mod_on`, `rec_pre_on`, `rec_mod_on`) are all 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Codec input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pb_pre_val | input | 7 | Playback pre-divider value (0 = 128) |
| pb_pre_req | input | 1 | Playback pre-divider enable request |
| pb_mod_val | input | 7 | Playback modulator divider value (0 = 128) |
| pb_mod_req | input | 1 | Playback modulator divider enable request |
| pb_osr_val | input | 10 | Playback oversampling value (0 = 1024) |
| rec_pre_val | input | 7 | Record pre-divider value (0 = 128) |
| rec_pre_req | input | 1 | Record pre-divider enable request |
| rec_mod_val | input | 7 | Record modulator divider value (0 = 128) |
| rec_mod_req | input | 1 | Record modulator divider enable request |
| rec_osr_val | input | 8 | Record oversampling value (0 = 256) |
| pb_pwr_dn_a | input | 1 | Playback power-status flag A (1 = powered down) |
| pb_pwr_dn_b | input | 1 | Playback power-status flag B (1 = powered down) |
| rec_pwr_dn | input | 1 | Record power-status flag (1 = powered down) |
| pb_mod_ce | output | 1 | Playback modulator clock enable |
| pb_fs_ce | output | 1 | Playback sample clock enable |
| rec_mod_ce | output | 1 | Record modulator clock enable |
| rec_fs_ce | output | 1 | Record sample clock enable |
| pb_pre_on | output | 1 | Playback pre-divider running |
| pb_mod_on | output | 1 | Playback modulator divider running |
| rec_pre_on | output | 1 | Record pre-divider running |
| rec_mod_on | output | 1 | Record modulator divider running |

## Verification
Some rules are checked by assertions on every cycle:
- the modulator divider stops before the pre-divider;
- no divider stops unless its status condition was met;
- a raised request starts a divider at the next edge;
- a running divider keeps its captured value;
- the record output mirrors playback while borrowing;
- sample pulses only coincide with modulator pulses.

Other behaviour can only be shown by the bench scenarios. These cover the exact pulse periods over a sweep of small divide values, the maximum-count decoding of zero, the deferred effect of a value change while running, the one-cycle gap between the modulator and pre-divider stopping, and the hold-off of playback shutdown while the record side borrows.

// File: rtl/audio_ce_pkg.sv
package audio_ce_pkg;
   localparam int PRE_W_DEF   = 7;
   localparam int MOD_W_DEF   = 7;
   localparam int PB_OSR_W    = 10;
   localparam int REC_OSR_W   = 8;
   localparam int MAX_DIV_W   = 16;
endpackage

// File: rtl/audio_ce_div.sv
module audio_ce_div #(
   parameter int W = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         ce_in,
   input  logic [W-1:0] div_val,
   output logic         ce_out
);
   import audio_ce_pkg::*;

   initial begin
      assert (W >= 1 && W <= MAX_DIV_W) else $error("audio_ce_div: W out of range");
   end

   logic [W-1:0] cnt;
   logic [W-1:0] last;
   logic         hit;

   // value 0 wraps to all ones, so the count runs to 2**W
   assign hit    = (cnt == last);
   assign ce_out = en && ce_in && hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         last <= '1;
      end else if (!en) begin
         cnt  <= '0;
         last <= div_val - W'(1);
      end else if (ce_in) begin
         cnt  <= hit ? '0 : cnt + W'(1);
      end
   end

   assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en)) |-> $stable(last));
   assert_restart_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !$past(en)) |-> (cnt == '0));
endmodule

// File: rtl/audio_div_seq.sv
module audio_div_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic req_pre,
   input  logic req_mod,
   input  logic chan_dn,
   input  logic hold,
   output logic pre_on,
   output logic mod_on
);
   logic may_stop;
   assign may_stop = chan_dn && !hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_on <= 1'b0;
         mod_on <= 1'b0;
      end else begin
         if (req_mod)       mod_on <= 1'b1;
         else if (may_stop) mod_on <= 1'b0;
         if (req_pre)                  pre_on <= 1'b1;
         else if (may_stop && !mod_on) pre_on <= 1'b0;
      end
   end

   assert_mod_before_pre_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pre_on) |-> !$past(mod_on));
   // covers R7 and R10 for the instance they apply to
   assert_status_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mod_on) |-> $past(chan_dn && !hold));
   assert_start_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_pre && rst_n) |-> pre_on);
endmodule

// File: rtl/audio_ce_chain.sv
module audio_ce_chain #(
   parameter int PRE_W = 7,
   parameter int MOD_W = 7,
   parameter int OSR_W = 10,
   parameter bit ALT   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pre_on,
   input  logic             mod_on,
   input  logic [PRE_W-1:0] pre_val,
   input  logic [MOD_W-1:0] mod_val,
   input  logic [OSR_W-1:0] osr_val,
   input  logic             alt_ce,
   input  logic             alt_ok,
   output logic             mod_ce,
   output logic             fs_ce
);
   logic pre_ce, own_ce, own_ok, src_ce, src_ok;

   audio_ce_div #(.W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .en(pre_on), .ce_in(1'b1),
      .div_val(pre_val), .ce_out(pre_ce));

   audio_ce_div #(.W(MOD_W)) u_mod (
      .clk(clk), .rst_n(rst_n), .en(mod_on), .ce_in(pre_ce),
      .div_val(mod_val), .ce_out(own_ce));

   assign own_ok = pre_on && mod_on;

   generate
      if (ALT) begin : g_alt
         logic use_alt;
         assign use_alt = !pre_on && !mod_on;
         assign src_ce  = use_alt ? alt_ce : own_ce;
         assign src_ok  = use_alt ? alt_ok : own_ok;
      end else begin : g_own
         logic unused_alt;
         assign unused_alt = alt_ce ^ alt_ok;
         assign src_ce     = own_ce;
         assign src_ok     = own_ok;
      end
   endgenerate

   audio_ce_div #(.W(OSR_W)) u_osr (
      .clk(clk), .rst_n(rst_n), .en(src_ok), .ce_in(src_ce),
      .div_val(osr_val), .ce_out(fs_ce));

   assign mod_ce = src_ce && src_ok;

   assert_fs_on_mod_R1: assert property (@(posedge clk) disable iff (!rst_n)
      fs_ce |-> mod_ce);
   assert_no_own_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !mod_on |-> !own_ce);
endmodule

// File: rtl/audio_ce_tree.sv
module audio_ce_tree #(
   parameter int PRE_W     = audio_ce_pkg::PRE_W_DEF,
   parameter int MOD_W     = audio_ce_pkg::MOD_W_DEF,
   parameter int PB_OSR_W  = audio_ce_pkg::PB_OSR_W,
   parameter int REC_OSR_W = audio_ce_pkg::REC_OSR_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PRE_W-1:0]     pb_pre_val,
   input  logic                 pb_pre_req,
   input  logic [MOD_W-1:0]     pb_mod_val,
   input  logic                 pb_mod_req,
   input  logic [PB_OSR_W-1:0]  pb_osr_val,
   input  logic [PRE_W-1:0]     rec_pre_val,
   input  logic                 rec_pre_req,
   input  logic [MOD_W-1:0]     rec_mod_val,
   input  logic                 rec_mod_req,
   input  logic [REC_OSR_W-1:0] rec_osr_val,
   input  logic                 pb_pwr_dn_a,
   input  logic                 pb_pwr_dn_b,
   input  logic                 rec_pwr_dn,
   output logic                 pb_mod_ce,
   output logic                 pb_fs_ce,
   output logic                 rec_mod_ce,
   output logic                 rec_fs_ce,
   output logic                 pb_pre_on,
   output logic                 pb_mod_on,
   output logic                 rec_pre_on,
   output logic                 rec_mod_on
);
   logic borrow, pb_hold, pb_dn, pb_ok;

   assign borrow  = !rec_pre_on && !rec_mod_on;
   assign pb_hold = borrow && !rec_pwr_dn;
   assign pb_dn   = pb_pwr_dn_a && pb_pwr_dn_b;
   assign pb_ok   = pb_pre_on && pb_mod_on;

   audio_div_seq u_pb_seq (
      .clk(clk), .rst_n(rst_n), .req_pre(pb_pre_req), .req_mod(pb_mod_req),
      .chan_dn(pb_dn), .hold(pb_hold), .pre_on(pb_pre_on), .mod_on(pb_mod_on));

   audio_div_seq u_rec_seq (
      .clk(clk), .rst_n(rst_n), .req_pre(rec_pre_req), .req_mod(rec_mod_req),
      .chan_dn(rec_pwr_dn), .hold(1'b0), .pre_on(rec_pre_on), .mod_on(rec_mod_on));

   audio_ce_chain #(.PRE_W(PRE_W), .MOD_W(MOD_W), .OSR_W(PB_OSR_W), .ALT(1'b0)) u_pb (
      .clk(clk), .rst_n(rst_n), .pre_on(pb_pre_on), .mod_on(pb_mod_on),
      .pre_val(pb_pre_val), .mod_val(pb_mod_val), .osr_val(pb_osr_val),
      .alt_ce(1'b0), .alt_ok(1'b0), .mod_ce(pb_mod_ce), .fs_ce(pb_fs_ce));

   audio_ce_chain #(.PRE_W(PRE_W), .MOD_W(MOD_W), .OSR_W(REC_OSR_W), .ALT(1'b1)) u_rec (
      .clk(clk), .rst_n(rst_n), .pre_on(rec_pre_on), .mod_on(rec_mod_on),
      .pre_val(rec_pre_val), .mod_val(rec_mod_val), .osr_val(rec_osr_val),
      .alt_ce(pb_mod_ce), .alt_ok(pb_ok), .mod_ce(rec_mod_ce), .fs_ce(rec_fs_ce));

   assert_borrow_mirror_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!rec_pre_on && !rec_mod_on) |-> (rec_mod_ce == pb_mod_ce));
   assert_borrow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(pb_mod_on) && $past(borrow)) |-> $past(rec_pwr_dn));
endmodule

// File: tb/audio_ce_tree_tb.sv
module audio_ce_tree_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [6:0] pb_pre_val = 7'd1, pb_mod_val = 7'd1, rec_pre_val = 7'd1, rec_mod_val = 7'd1;
   logic [9:0] pb_osr_val = 10'd1;
   logic [7:0] rec_osr_val = 8'd1;
   logic pb_pre_req = 0, pb_mod_req = 0, rec_pre_req = 0, rec_mod_req = 0;
   logic pb_pwr_dn_a = 1, pb_pwr_dn_b = 1, rec_pwr_dn = 1;
   logic pb_mod_ce, pb_fs_ce, rec_mod_ce, rec_fs_ce;
   logic pb_pre_on, pb_mod_on, rec_pre_on, rec_mod_on;
   int total = 0, bad = 0, cyc = 0;

   always #2 clk = ~clk;

   audio_ce_tree u_dut (.*);

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input string req, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
      end
   endtask

   function automatic logic pick(input int sel);
      case (sel)
         0: return pb_mod_ce;
         1: return pb_fs_ce;
         2: return rec_mod_ce;
         default: return rec_fs_ce;
      endcase
   endfunction

   task automatic meas(input int sel, output int per);
      int g = 0;
      while (!pick(sel) && g < 6000) begin @(negedge clk); g++; end
      if (g >= 6000) begin per = -1; return; end
      @(negedge clk);
      per = 1;
      while (!pick(sel) && per < 6000) begin @(negedge clk); per++; end
   endtask

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pb_stop();
      pb_pre_req = 0; pb_mod_req = 0; pb_pwr_dn_a = 1; pb_pwr_dn_b = 1;
      wait_n(4);
   endtask

   task automatic pb_start(input int n, input int m, input int o);
      pb_pre_val = 7'(n); pb_mod_val = 7'(m); pb_osr_val = 10'(o);
      @(negedge clk);
      pb_pre_req = 1; pb_mod_req = 1;
      wait_n(2);
   endtask

   task automatic rec_stop();
      rec_pre_req = 0; rec_mod_req = 0; rec_pwr_dn = 1;
      wait_n(4);
   endtask

   task automatic rec_start(input int n, input int m, input int o);
      rec_pre_val = 7'(n); rec_mod_val = 7'(m); rec_osr_val = 8'(o);
      @(negedge clk);
      rec_pre_req = 1; rec_mod_req = 1;
      wait_n(2);
   endtask

   // returns cycles between modulator stop and pre stop (-1 if not seen)
   task automatic order_gap(input bit pb, output int gap);
      int tm = -1, tn = -1;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (tm < 0 && !(pb ? pb_mod_on : rec_mod_on)) tm = i;
         if (tn < 0 && !(pb ? pb_pre_on : rec_pre_on)) tn = i;
      end
      gap = (tm < 0 || tn < 0) ? -1 : tn - tm;
   endtask

   initial begin
      int p, cnt;
      wait_n(3);
      rst_n = 1;
      // R11 reset state
      cnt = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         cnt += int'(pb_mod_ce) + int'(pb_fs_ce) + int'(rec_mod_ce) + int'(rec_fs_ce);
      end
      chk("R11 reset flags", {pb_pre_on, pb_mod_on, rec_pre_on, rec_mod_on}, 0);
      chk("R11 reset pulses", cnt, 0);

      // R5 start at next edge
      pb_pre_val = 1; pb_mod_val = 1; pb_osr_val = 1;
      @(negedge clk);
      pb_pre_req = 1; pb_mod_req = 1;
      @(negedge clk);
      chk("R5 flags", {pb_pre_on, pb_mod_on}, 3);
      chk("R5 first pulse", pb_mod_ce, 1);
      pb_stop();

      // R1 playback sweep
      for (int n = 1; n <= 3; n++)
         for (int m = 1; m <= 3; m++)
            for (int o = 1; o <= 3; o++) begin
               pb_start(n, m, o);
               meas(0, p); chk("R1 pb mod period", p, n * m);
               meas(1, p); chk("R1 pb fs period", p, n * m * o);
               pb_stop();
            end

      // R2 record sweep
      for (int n = 1; n <= 3; n++)
         for (int m = 1; m <= 3; m++)
            for (int o = 1; o <= 2; o++) begin
               rec_start(n, m, o);
               meas(2, p); chk("R2 rec mod period", p, n * m);
               meas(3, p); chk("R2 rec fs period", p, n * m * o);
               rec_stop();
            end

      // R3 zero means max
      pb_start(0, 1, 1); meas(0, p); chk("R3 pb pre zero", p, 128); pb_stop();
      pb_start(1, 0, 1); meas(0, p); chk("R3 pb mod zero", p, 128); pb_stop();
      pb_start(1, 1, 0); meas(1, p); chk("R3 pb osr zero", p, 1024); pb_stop();
      rec_start(0, 1, 1); meas(2, p); chk("R3 rec pre zero", p, 128); rec_stop();
      rec_start(1, 1, 0); meas(3, p); chk("R3 rec osr zero", p, 256); rec_stop();

      // R4 values frozen while running
      pb_start(2, 1, 2);
      pb_pre_val = 3; pb_osr_val = 5;
      wait_n(3);
      meas(0, p); chk("R4 running mod unchanged", p, 2);
      meas(1, p); chk("R4 running fs unchanged", p, 4);
      pb_stop();
      pb_start(3, 1, 5);
      meas(0, p); chk("R4 restart mod", p, 3);
      meas(1, p); chk("R4 restart fs", p, 15);
      pb_stop();

      // R6 / R8 playback status-gated shutdown (record runs, so no borrow)
      rec_start(1, 1, 1);
      pb_pwr_dn_a = 0; pb_pwr_dn_b = 0;
      pb_start(1, 1, 1);
      pb_pre_req = 0; pb_mod_req = 0;
      wait_n(20);
      chk("R6 held no flags", {pb_pre_on, pb_mod_on}, 3);
      meas(0, p); chk("R6 still pulsing", p, 1);
      pb_pwr_dn_a = 1;
      wait_n(10);
      chk("R6 held one flag", {pb_pre_on, pb_mod_on}, 3);
      pb_pwr_dn_b = 1;
      order_gap(1'b1, p);
      chk("R8 pb mod then pre gap", p, 1);
      chk("R6 off after flags", {pb_pre_on, pb_mod_on}, 0);

      // R7 / R8 record status-gated shutdown
      rec_pwr_dn = 0;
      rec_pre_req = 0; rec_mod_req = 0;
      wait_n(20);
      chk("R7 held", {rec_pre_on, rec_mod_on}, 3);
      meas(2, p); chk("R7 still pulsing", p, 1);
      rec_pwr_dn = 1;
      order_gap(1'b0, p);
      chk("R8 rec mod then pre gap", p, 1);
      chk("R7 off after flag", {rec_pre_on, rec_mod_on}, 0);

      // R9 record borrows playback
      rec_osr_val = 3;
      wait_n(2);
      pb_start(2, 2, 1);
      chk("R9 rec dividers idle", {rec_pre_on, rec_mod_on}, 0);
      meas(2, p); chk("R9 borrowed mod period", p, 4);
      meas(3, p); chk("R9 borrowed fs period", p, 12);

      // R10 borrow holds playback dividers
      rec_pwr_dn = 0;
      pb_pre_req = 0; pb_mod_req = 0;
      wait_n(20);
      chk("R10 pb held by borrow", {pb_pre_on, pb_mod_on}, 3);
      meas(2, p); chk("R10 rec still fed", p, 4);
      rec_pwr_dn = 1;
      wait_n(5);
      chk("R10 pb off after rec flag", {pb_pre_on, pb_mod_on}, 0);
      cnt = 0;
      for (int i = 0; i < 100; i++) begin @(negedge clk); cnt += int'(rec_mod_ce); end
      chk("R10 rec quiet after", cnt, 0);

      // R11 pre alone emits nothing
      pb_pre_val = 1;
      @(negedge clk);
      pb_pre_req = 1;
      cnt = 0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         cnt += int'(pb_mod_ce) + int'(pb_fs_ce) + int'(rec_mod_ce);
      end
      chk("R11 pre-only flags", {pb_pre_on, pb_mod_on}, 2);
      chk("R11 pre-only pulses", cnt, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule